// File: doc/BRIEF.md
# Debug Exception Router with Pipeline Stall

This block sits beside a processor's exception logic and decides, for every exception the core raises, whether the normal handler takes it or whether it is handed to an external debugger. Each exception kind has its own stop-mask bit. When an exception whose mask bit is set arrives, the block raises a divert flag in the same cycle. The exception vectoring logic uses that flag to suppress the normal handler. The block also records the kind in a sticky reason register and requests a pipeline stall, so the debugger can take control.

The exception arrives as a valid strobe plus a 4-bit kind code. Codes 0 to 12 name the thirteen supported kinds. Codes 13 to 15 stand for kinds outside that list, and these are never diverted. Software reads the reason register and clears individual bits by writing ones to them. The stall output merges the internal stall request with an external stall request. A debugger-disable input forces the stall output low.

Top module: `dbg_exc_router`

## Requirements
- R1: Kind codes are: 0 reset, 1 bus error, 2 data page fault, 3 instruction page fault, 4 tick timer, 5 alignment, 6 illegal instruction, 7 external interrupt, 8 data TLB miss, 9 instruction TLB miss, 10 range, 11 system call, 12 trap. Code k is governed by stop-mask bit k and is recorded in reason bit k.
- R2: `divert_o` is high in the same cycle as `exc_valid` exactly when the code is 0 to 12 and `stop_mask[code]` is 1. It is low in every other cycle.
- R3: A diverted exception of code k sets `reason_o[k]` from the next cycle on. Reason bits are sticky and accumulate across events; only reset or a clear write lowers them.
- R4: When `rsn_clr_we` is 1, each reason bit whose `rsn_clr_bits` bit is 1 is cleared in the next cycle, and bits written 0 are unchanged. If a bit is set by a diversion in the same cycle as it is cleared, it ends up set.
- R5: A diverted exception sets the internal stall request from the next cycle on.
- R6: A valid exception that is not diverted, including one with code 13 to 15, clears the internal stall request from the next cycle on. Cycles without `exc_valid` leave the request unchanged.
- R7: `stall_o` equals (internal stall request OR `ext_stall_req`) AND NOT `dbg_disable`, combinationally. It is therefore always low while `dbg_disable` is 1.
- R8: Codes 13, 14 and 15 never raise `divert_o` and never set a reason bit, whatever the mask holds.
- R9: After reset all reason bits are 0 and the internal stall request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | An exception is raised this cycle |
| exc_code | input | 4 | Kind code of the exception |
| stop_mask | input | 13 | Per-kind steer-to-debugger enables |
| dbg_disable | input | 1 | Debugger disabled; forces stall low |
| ext_stall_req | input | 1 | Stall request from the external debugger |
| rsn_clr_we | input | 1 | Clear strobe for the reason register |
| rsn_clr_bits | input | 13 | Write-one-to-clear bits for the reason register |
| divert_o | output | 1 | Exception goes to the debugger, not the handler |
| reason_o | output | 13 | Sticky debug reason bits |
| stall_o | output | 1 | Stall to the pipeline |

## Verification
The hardest case to produce is a clear write that lands in the same cycle as a diversion of the same kind. In that case set must beat clear. A neighbouring cleared bit must still fall, and the stall request must still switch. Random stimulus rarely lines these up. Directed cycles therefore drive a chosen code with its mask bit set together with a clear pattern covering that bit and another bit already set. The random phase biases the clear strobe and the mask so that such overlaps, and unknown codes arriving while the stall is held, recur many times against the bench's model.

// File: rtl/dbg_route_pkg.sv
package dbg_route_pkg;
    localparam int unsigned EXC_KINDS  = 13;
    localparam int unsigned EXC_CODE_W = 4;

    typedef enum logic [EXC_CODE_W-1:0] {
        EK_RESET    = 4'd0,
        EK_BUS_ERR  = 4'd1,
        EK_DPAGE    = 4'd2,
        EK_IPAGE    = 4'd3,
        EK_TICK     = 4'd4,
        EK_ALIGN    = 4'd5,
        EK_ILLEGAL  = 4'd6,
        EK_EXT_INT  = 4'd7,
        EK_DTLB     = 4'd8,
        EK_ITLB     = 4'd9,
        EK_RANGE    = 4'd10,
        EK_SYSCALL  = 4'd11,
        EK_TRAP     = 4'd12
    } exc_kind_e;
endpackage

// File: rtl/exc_decode.sv
module exc_decode #(
    parameter int unsigned NUM_KINDS = dbg_route_pkg::EXC_KINDS,
    parameter int unsigned CODE_W    = dbg_route_pkg::EXC_CODE_W
) (
    input  logic                 exc_valid,
    input  logic [CODE_W-1:0]    exc_code,
    output logic [NUM_KINDS-1:0] kind_hot
);
    // One comparator per supported kind; codes beyond the list match nothing.
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        assign kind_hot[k] = exc_valid && (exc_code == CODE_W'(k));
    end

    always_comb begin
        assert ($onehot0(kind_hot));
    end
endmodule

// File: rtl/dbg_reason_reg.sv
module dbg_reason_reg #(
    parameter int unsigned NUM_KINDS = dbg_route_pkg::EXC_KINDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] set_vec,
    input  logic                 clr_we,
    input  logic [NUM_KINDS-1:0] clr_vec,
    output logic [NUM_KINDS-1:0] reason_q
);
    typedef struct packed {
        logic [NUM_KINDS-1:0] bits;
    } rsn_state_t;

    rsn_state_t st_d, st_q;
    logic [NUM_KINDS-1:0] clr_eff;

    always_comb begin
        st_d    = st_q;
        clr_eff = clr_we ? clr_vec : '0;
        // New events win over a clear of the same bit.
        st_d.bits = (st_q.bits & ~clr_eff) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reason_q = st_q.bits;

    // Without a clear write no bit may fall.
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((reason_q & $past(reason_q)) == $past(reason_q)));

    // A cleared bit that was not set in the same cycle must be low afterwards.
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((reason_q & $past(clr_vec) & ~$past(set_vec)) == '0));

    // A set bit must be high afterwards, whatever the clear pattern.
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((reason_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/dbg_stall_ctl.sv
module dbg_stall_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_valid,
    input  logic divert,
    input  logic ext_stall_req,
    input  logic dbg_disable,
    output logic stall_o
);
    typedef struct packed {
        logic req;
    } stall_state_t;

    stall_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (exc_valid) begin
            st_d.req = divert;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_o = (st_q.req | ext_stall_req) & ~dbg_disable;

    p_divert_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (divert && !dbg_disable) |=> (stall_o || dbg_disable));

    p_taken_unstalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !divert) |=> (stall_o == (ext_stall_req && !dbg_disable)));

    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid && !dbg_disable && !ext_stall_req && !stall_o) |=> (stall_o == (ext_stall_req && !dbg_disable)));
endmodule

// File: rtl/dbg_exc_router.sv
module dbg_exc_router #(
    parameter int unsigned NUM_KINDS = dbg_route_pkg::EXC_KINDS,
    parameter int unsigned CODE_W    = dbg_route_pkg::EXC_CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_valid,
    input  logic [CODE_W-1:0]    exc_code,
    input  logic [NUM_KINDS-1:0] stop_mask,
    input  logic                 dbg_disable,
    input  logic                 ext_stall_req,
    input  logic                 rsn_clr_we,
    input  logic [NUM_KINDS-1:0] rsn_clr_bits,
    output logic                 divert_o,
    output logic [NUM_KINDS-1:0] reason_o,
    output logic                 stall_o
);
    logic [NUM_KINDS-1:0] kind_hot;
    logic [NUM_KINDS-1:0] steer_hot;

    exc_decode #(.NUM_KINDS(NUM_KINDS), .CODE_W(CODE_W)) u_dec (
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .kind_hot  (kind_hot)
    );

    assign steer_hot = kind_hot & stop_mask;
    assign divert_o  = |steer_hot;

    dbg_reason_reg #(.NUM_KINDS(NUM_KINDS)) u_rsn (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (steer_hot),
        .clr_we   (rsn_clr_we),
        .clr_vec  (rsn_clr_bits),
        .reason_q (reason_o)
    );

    dbg_stall_ctl u_stall (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_valid     (exc_valid),
        .divert        (divert_o),
        .ext_stall_req (ext_stall_req),
        .dbg_disable   (dbg_disable),
        .stall_o       (stall_o)
    );

    p_unknown_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && (exc_code >= CODE_W'(NUM_KINDS))) |-> !divert_o);

    p_divert_records_r3: assert property (@(posedge clk) disable iff (!rst_n)
        divert_o |=> (((reason_o >> $past(exc_code)) & NUM_KINDS'(1)) != '0));

    p_divert_only_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> !divert_o);

    p_disable_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_disable |-> !stall_o);
endmodule

// File: tb/tb_dbg_exc_router.sv
`timescale 1ns/1ps
module tb_dbg_exc_router;
    localparam int NK = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exc_valid = 1'b0;
    logic [3:0]    exc_code = '0;
    logic [NK-1:0] stop_mask = '0;
    logic          dbg_disable = 1'b0;
    logic          ext_stall_req = 1'b0;
    logic          rsn_clr_we = 1'b0;
    logic [NK-1:0] rsn_clr_bits = '0;
    logic          divert_o;
    logic [NK-1:0] reason_o;
    logic          stall_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [NK-1:0] m_reason = '0;
    logic          m_req = 1'b0;
    bit            done = 0;

    always #5 clk = ~clk;

    dbg_exc_router dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .stop_mask(stop_mask), .dbg_disable(dbg_disable), .ext_stall_req(ext_stall_req),
        .rsn_clr_we(rsn_clr_we), .rsn_clr_bits(rsn_clr_bits),
        .divert_o(divert_o), .reason_o(reason_o), .stall_o(stall_o)
    );

    function automatic logic exp_divert(logic v, logic [3:0] c, logic [NK-1:0] m);
        return v && (c < 4'd13) && m[c];
    endfunction

    function automatic logic exp_stall(logic req, logic ext, logic dis);
        return (req | ext) & ~dis;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: compare registered state, drive inputs, compare combinational outputs, advance model.
    task automatic cyc(logic v, logic [3:0] c, logic [NK-1:0] m, logic dis, logic ext,
                       logic cwe, logic [NK-1:0] cb, string tag);
        logic d;
        @(negedge clk);
        check({tag, " R3 reason"}, 32'(reason_o), 32'(m_reason));
        exc_valid = v; exc_code = c; stop_mask = m; dbg_disable = dis;
        ext_stall_req = ext; rsn_clr_we = cwe; rsn_clr_bits = cb;
        #1;
        d = exp_divert(v, c, m);
        check((c >= 4'd13 && v) ? {tag, " R8 divert"} : {tag, " R2 divert"}, 32'(divert_o), 32'(d));
        check({tag, " R7 stall"}, 32'(stall_o), 32'(exp_stall(m_req, ext, dis)));
        @(posedge clk);
        m_reason = (m_reason & ~(cwe ? cb : '0)) | (d ? NK'(1) << c : '0);
        if (v) m_req = d;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9 reset state
        #1;
        check("R9 reset reason", 32'(reason_o), 0);
        check("R9 reset stall", 32'(stall_o), 0);

        // R2 mask clear: no divert, R6 request stays low
        cyc(1, 4'd5, '0, 0, 0, 0, '0, "mask clear");
        // R1/R3 every kind diverted in turn accumulates
        for (int k = 0; k < NK; k++)
            cyc(1, 4'(k), NK'(1) << k, 0, 0, 0, '0, "R1 each kind");
        cyc(0, 0, '0, 0, 0, 0, '0, "R3 all set");
        check("R3 all bits accumulated", 32'(reason_o), 32'(13'h1FFF));
        check("R5 stall after divert", 32'(stall_o), 1);
        // R7 disable forces low
        cyc(0, 0, '0, 1, 1, 0, '0, "R7 disable");
        // R4 partial clear
        cyc(0, 0, '0, 0, 0, 1, 13'h00F0, "R4 clear");
        cyc(0, 0, '0, 0, 0, 0, '0, "R4 after");
        check("R4 partial clear", 32'(reason_o), 32'(13'h1F0F));
        // R4 set beats clear on same bit, neighbour falls
        cyc(0, 0, '0, 0, 0, 1, 13'h1FFF, "R4 wipe");
        cyc(1, 4'd11, 13'h0800, 0, 0, 1, 13'h0800, "R4 same cycle");
        cyc(1, 4'd2, 13'h0004, 0, 0, 0, '0, "R4 set2");
        cyc(1, 4'd2, 13'h0004, 0, 0, 1, 13'h0804, "R4 collide");
        cyc(0, 0, '0, 0, 0, 0, '0, "R4 check");
        check("R4 set wins, neighbour cleared", 32'(reason_o), 32'(13'h0004));
        // R8 unknown codes with full mask, R6 they clear the stall request
        cyc(1, 4'd13, 13'h1FFF, 0, 0, 0, '0, "R8 code13");
        cyc(1, 4'd15, 13'h1FFF, 0, 0, 0, '0, "R8 code15");
        cyc(0, 0, '0, 0, 0, 0, '0, "R6 after unknown");
        check("R6 unknown clears stall", 32'(stall_o), 0);
        check("R8 no reason from unknown", 32'(reason_o), 32'(13'h0004));
        // R7 external stall alone
        cyc(0, 0, '0, 0, 1, 0, '0, "R7 ext");
        // R6 idle cycles hold request
        cyc(1, 4'd7, 13'h0080, 0, 0, 0, '0, "R5 set");
        cyc(0, 0, '0, 0, 0, 0, '0, "R6 hold");
        cyc(0, 0, '0, 0, 0, 0, '0, "R6 hold2");
        cyc(1, 4'd7, 13'h0000, 0, 0, 0, '0, "R6 taken");

        // Random phase with bias toward overlaps
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] c = 4'($urandom_range(0, 15));
            logic [NK-1:0] m = ($urandom_range(0, 3) == 0) ? NK'($urandom) : (NK'($urandom) | (NK'(1) << c));
            logic [NK-1:0] cb = NK'($urandom) | (($urandom_range(0, 1) == 1) ? (NK'(1) << c) : '0);
            cyc(logic'($urandom_range(0, 2) != 0), c, m,
                logic'($urandom_range(0, 7) == 0), logic'($urandom_range(0, 4) == 0),
                logic'($urandom_range(0, 3) == 0), cb, "rand");
        end

        // R9 reset mid-run clears state
        @(negedge clk); rst_n = 1'b0; exc_valid = 0; ext_stall_req = 0; dbg_disable = 0; rsn_clr_we = 0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R9 re-reset reason", 32'(reason_o), 0);
        check("R9 re-reset stall", 32'(stall_o), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule